// File: doc/BRIEF.md
# Memory-mapped dual-channel GPIO controller

This block is a general purpose I/O peripheral reached through a 32-bit AXI4-Lite slave port. It holds one channel of pins, or two when the dual-channel parameter is set, and each channel is 1 to 32 bits wide. Every channel has an output value register and a direction register. Software can therefore turn any pin into an input or an output at run time. The block presents separate pin-in, pin-out and per-bit high-impedance enable buses, so the pad buffers stay outside it.

Pin inputs pass through a two-flop synchroniser before a read returns them. The synchronised values also leave the block, so that a separate interrupt block can detect edges on them. The bus side accepts one transaction at a time, registers its read data and always answers OKAY.

Top module: `gpio_lite_ctrl`

## Requirements
- R1: Out of reset each channel drives its output bus with its data reset parameter and its enable bus with its direction reset parameter. The direction reset parameter defaults to all ones, so every pin is high impedance.
- R2: A write completes only in a cycle where address-valid and data-valid are both high. While only one of them is high, neither ready rises and no register changes. While a response is pending, no new address is accepted on either channel of the bus. A write offered together with a read is taken first.
- R3: A write stores the whole 32-bit data word whatever the byte strobes are.
- R4: A write to a data register (channel 1 at 0x0, channel 2 at 0x8) updates every bit whose direction bit is 0. The new value appears on the output bus in the cycle after the write handshake.
- R5: A data register write leaves unchanged every bit whose direction bit is 1. The old value is visible on the output bus once that bit is later turned into an output.
- R6: A data register read returns, for a bit whose direction bit is 1, the pin value after two clock stages of synchronisation, and returns 0 for a bit whose direction bit is 0. The synchronised pin bus follows the pin input two cycles later.
- R7: The direction register (channel 1 at 0x4, channel 2 at 0xC) drives the enable bus directly: bit value 1 means input (high impedance) and 0 means output. A read of it returns the stored value.
- R8: The channel 2 registers work independently of channel 1, and a write to one channel leaves the pins of the other unchanged.
- R9: With the dual-channel parameter clear, writes to 0x8 and 0xC have no effect and reads from them return 0. The channel 2 output bus stays at 0 and its enable bus stays at all ones.
- R10: Read data bits at or above the channel width are 0. Offsets from 0x10 upward read as 0, and writes to them change nothing.
- R11: Every response is OKAY (00). Read data appears one cycle after the address handshake and holds steady with valid high until the master accepts it. A write response likewise holds until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ch1_in | input | W1 | Channel 1 pin inputs |
| ch1_out | output | W1 | Channel 1 pin outputs |
| ch1_hiz | output | W1 | Channel 1 per-bit high-impedance enable |
| ch1_in_sync | output | W1 | Channel 1 synchronised pin inputs |
| ch2_in | input | W2 | Channel 2 pin inputs |
| ch2_out | output | W2 | Channel 2 pin outputs |
| ch2_hiz | output | W2 | Channel 2 per-bit high-impedance enable |
| ch2_in_sync | output | W2 | Channel 2 synchronised pin inputs |

## Verification
The data path is tried with mixed direction masks: all-output, upper-nibble input and a middle-field input on channel 2. A value written under a mask shows on the pins only where the mask allows it, and masked bits keep their old value once the mask is cleared. Pin patterns such as 0xA6 and 0x5B, read through a partial mask, separate synchronised pin data from zero-filled output bits. Single-valid stimulus, a read held with ready low, and out-of-range and disabled-channel offsets probe the handshake and decode corners.

// File: rtl/gpio_lite_pkg.sv
package gpio_lite_pkg;
  localparam int BUS_W       = 32;
  localparam int REG_WORDS   = 4;
  localparam int SYNC_STAGES = 2;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  localparam int IDX_DATA1 = 0;
  localparam int IDX_DIR1  = 1;
  localparam int IDX_DATA2 = 2;
  localparam int IDX_DIR2  = 3;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRESP = 2'd1,
    BUS_RRESP = 2'd2
  } bus_state_t;
endpackage

// File: rtl/gpio_lite_sync.sv
module gpio_lite_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lite_chan.sv
module gpio_lite_chan
  import gpio_lite_pkg::*;
#(
  parameter int               W        = 8,
  parameter logic [BUS_W-1:0] DATA_RST = '0,
  parameter logic [BUS_W-1:0] DIR_RST  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [BUS_W-1:0] wr_word,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_hiz,
  output logic [W-1:0]     pin_sync,
  output logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] rd_dir
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic         wide_unused;

  assign wide_unused = ^wr_word;

  gpio_lite_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= DATA_RST[W-1:0];
      dir_q  <= DIR_RST[W-1:0];
    end else begin
      if (dir_we)
        dir_q <= wr_word[W-1:0];
      if (data_we)
        data_q <= (data_q & dir_q) | (wr_word[W-1:0] & ~dir_q);
    end
  end

  assign pin_out = data_q;
  assign pin_hiz = dir_q;

  always_comb begin
    rd_data         = '0;
    rd_dir          = '0;
    rd_data[W-1:0]  = pin_sync & dir_q;
    rd_dir[W-1:0]   = dir_q;
  end
endmodule

// File: rtl/gpio_lite_axil.sv
module gpio_lite_axil
  import gpio_lite_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [BUS_W-1:0]     wdata,
  input  logic                 wvalid,
  output logic                 wready,
  output logic [1:0]           bresp,
  output logic                 bvalid,
  input  logic                 bready,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic                 arvalid,
  output logic                 arready,
  output logic [BUS_W-1:0]     rdata,
  output logic [1:0]           rresp,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [REG_WORDS-1:0] wr_sel,
  output logic [BUS_W-1:0]     wr_word,
  output logic [1:0]           rd_idx,
  input  logic [BUS_W-1:0]     rd_value
);
  bus_state_t state_q;
  logic       idle;
  logic       w_fire;
  logic       ar_fire;
  logic       aw_hit;
  logic       ar_hit;
  logic       low_unused;

  assign low_unused = ^{awaddr[1:0], araddr[1:0]};

  assign idle    = (state_q == BUS_IDLE);
  assign awready = idle && awvalid && wvalid;
  assign wready  = awready;
  assign arready = idle && arvalid && !(awvalid && wvalid);
  assign w_fire  = awready;
  assign ar_fire = arready;

  assign aw_hit  = (awaddr >> 4) == '0;
  assign ar_hit  = (araddr >> 4) == '0;
  assign rd_idx  = araddr[3:2];
  assign wr_word = wdata;
  assign bresp   = RESP_OKAY;
  assign rresp   = RESP_OKAY;

  always_comb begin
    for (int i = 0; i < REG_WORDS; i++)
      wr_sel[i] = w_fire && aw_hit && (awaddr[3:2] == 2'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      bvalid  <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      unique case (state_q)
        BUS_IDLE: begin
          if (w_fire) begin
            state_q <= BUS_WRESP;
            bvalid  <= 1'b1;
          end else if (ar_fire) begin
            state_q <= BUS_RRESP;
            rvalid  <= 1'b1;
            rdata   <= ar_hit ? rd_value : '0;
          end
        end
        BUS_WRESP: begin
          if (bready) begin
            state_q <= BUS_IDLE;
            bvalid  <= 1'b0;
          end
        end
        BUS_RRESP: begin
          if (rready) begin
            state_q <= BUS_IDLE;
            rvalid  <= 1'b0;
          end
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_lite_ctrl.sv
module gpio_lite_ctrl
  import gpio_lite_pkg::*;
#(
  parameter bit               DUAL    = 1'b1,
  parameter int               W1      = 32,
  parameter int               W2      = 32,
  parameter int               ADDR_W  = 9,
  parameter logic [BUS_W-1:0] D1_RST  = '0,
  parameter logic [BUS_W-1:0] DIR1_RST = '1,
  parameter logic [BUS_W-1:0] D2_RST  = '0,
  parameter logic [BUS_W-1:0] DIR2_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [W1-1:0]     ch1_in,
  output logic [W1-1:0]     ch1_out,
  output logic [W1-1:0]     ch1_hiz,
  output logic [W1-1:0]     ch1_in_sync,
  input  logic [W2-1:0]     ch2_in,
  output logic [W2-1:0]     ch2_out,
  output logic [W2-1:0]     ch2_hiz,
  output logic [W2-1:0]     ch2_in_sync
);
  logic [REG_WORDS-1:0] wr_sel;
  logic [BUS_W-1:0]     wr_word;
  logic [1:0]           rd_idx;
  logic [BUS_W-1:0]     rd_value;
  logic [BUS_W-1:0]     c1_data, c1_dir, c2_data, c2_dir;
  logic                 strb_unused;

  assign strb_unused = ^s_wstrb;

  gpio_lite_axil #(.ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .awaddr   (s_awaddr),
    .awvalid  (s_awvalid),
    .awready  (s_awready),
    .wdata    (s_wdata),
    .wvalid   (s_wvalid),
    .wready   (s_wready),
    .bresp    (s_bresp),
    .bvalid   (s_bvalid),
    .bready   (s_bready),
    .araddr   (s_araddr),
    .arvalid  (s_arvalid),
    .arready  (s_arready),
    .rdata    (s_rdata),
    .rresp    (s_rresp),
    .rvalid   (s_rvalid),
    .rready   (s_rready),
    .wr_sel   (wr_sel),
    .wr_word  (wr_word),
    .rd_idx   (rd_idx),
    .rd_value (rd_value)
  );

  gpio_lite_chan #(.W(W1), .DATA_RST(D1_RST), .DIR_RST(DIR1_RST)) u_ch1 (
    .clk      (clk),
    .rst      (rst),
    .data_we  (wr_sel[IDX_DATA1]),
    .dir_we   (wr_sel[IDX_DIR1]),
    .wr_word  (wr_word),
    .pin_in   (ch1_in),
    .pin_out  (ch1_out),
    .pin_hiz  (ch1_hiz),
    .pin_sync (ch1_in_sync),
    .rd_data  (c1_data),
    .rd_dir   (c1_dir)
  );

  generate
    if (DUAL) begin : g_ch2
      gpio_lite_chan #(.W(W2), .DATA_RST(D2_RST), .DIR_RST(DIR2_RST)) u_ch2 (
        .clk      (clk),
        .rst      (rst),
        .data_we  (wr_sel[IDX_DATA2]),
        .dir_we   (wr_sel[IDX_DIR2]),
        .wr_word  (wr_word),
        .pin_in   (ch2_in),
        .pin_out  (ch2_out),
        .pin_hiz  (ch2_hiz),
        .pin_sync (ch2_in_sync),
        .rd_data  (c2_data),
        .rd_dir   (c2_dir)
      );
    end else begin : g_no_ch2
      logic ch2_unused;
      assign ch2_unused  = ^{ch2_in, wr_sel[IDX_DATA2], wr_sel[IDX_DIR2]};
      assign ch2_out     = '0;
      assign ch2_hiz     = '1;
      assign ch2_in_sync = '0;
      assign c2_data     = '0;
      assign c2_dir      = '0;
    end
  endgenerate

  always_comb begin
    unique case (rd_idx)
      2'd0:    rd_value = c1_data;
      2'd1:    rd_value = c1_dir;
      2'd2:    rd_value = c2_data;
      default: rd_value = c2_dir;
    endcase
  end
endmodule

// File: rtl/gpio_lite_chk.sv
module gpio_lite_chk #(
  parameter bit DUAL   = 1'b1,
  parameter int W1     = 32,
  parameter int W2     = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          s_awvalid,
  input logic          s_awready,
  input logic          s_wvalid,
  input logic [1:0]    s_bresp,
  input logic          s_bvalid,
  input logic          s_bready,
  input logic          s_arready,
  input logic [31:0]   s_rdata,
  input logic [1:0]    s_rresp,
  input logic          s_rvalid,
  input logic          s_rready,
  input logic [W1-1:0] ch1_in,
  input logic [W1-1:0] ch1_out,
  input logic [W1-1:0] ch1_hiz,
  input logic [W1-1:0] ch1_in_sync,
  input logic [W2-1:0] ch2_out,
  input logic [W2-1:0] ch2_hiz
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  pins_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(s_awvalid && s_wvalid) |-> ($stable(ch1_out) && $stable(ch1_hiz)
                                      && $stable(ch2_out) && $stable(ch2_hiz)));

  // R2
  one_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid) |-> (!s_awready && !s_arready && !(s_bvalid && s_rvalid)));

  // R11
  okay_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid |-> s_bresp == 2'b00) and (s_rvalid |-> s_rresp == 2'b00));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

  // R11
  bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (ch1_in_sync == $past(ch1_in, 2)));

  // R9
  ch2_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (DUAL == 1'b0) |-> (ch2_out == '0 && ch2_hiz == '1));
endmodule

bind gpio_lite_ctrl gpio_lite_chk #(.DUAL(DUAL), .W1(W1), .W2(W2)) u_chk (.*);

// File: tb/gpio_lite_ctrl_test.sv
module gpio_lite_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [8:0]  awaddr [2];
  logic        awvalid[2];
  logic        awready[2];
  logic [31:0] wdata  [2];
  logic [3:0]  wstrb  [2];
  logic        wvalid [2];
  logic        wready [2];
  logic [1:0]  bresp  [2];
  logic        bvalid [2];
  logic        bready [2];
  logic [8:0]  araddr [2];
  logic        arvalid[2];
  logic        arready[2];
  logic [31:0] rdata  [2];
  logic [1:0]  rresp  [2];
  logic        rvalid [2];
  logic        rready [2];

  logic [7:0]  c1_in, c1_out, c1_hiz, c1_sync;
  logic [11:0] c2_in, c2_out, c2_hiz, c2_sync;
  logic [3:0]  s1_in, s1_out, s1_hiz, s1_sync;
  logic [2:0]  s2_in, s2_out, s2_hiz, s2_sync;

  gpio_lite_ctrl #(.DUAL(1'b1), .W1(8), .W2(12), .D1_RST(32'hA5), .DIR1_RST(32'h0F),
                   .D2_RST(32'h0), .DIR2_RST(32'hFFFF_FFFF)) uut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr[0]), .s_awvalid(awvalid[0]), .s_awready(awready[0]),
    .s_wdata(wdata[0]), .s_wstrb(wstrb[0]), .s_wvalid(wvalid[0]), .s_wready(wready[0]),
    .s_bresp(bresp[0]), .s_bvalid(bvalid[0]), .s_bready(bready[0]),
    .s_araddr(araddr[0]), .s_arvalid(arvalid[0]), .s_arready(arready[0]),
    .s_rdata(rdata[0]), .s_rresp(rresp[0]), .s_rvalid(rvalid[0]), .s_rready(rready[0]),
    .ch1_in(c1_in), .ch1_out(c1_out), .ch1_hiz(c1_hiz), .ch1_in_sync(c1_sync),
    .ch2_in(c2_in), .ch2_out(c2_out), .ch2_hiz(c2_hiz), .ch2_in_sync(c2_sync)
  );

  gpio_lite_ctrl #(.DUAL(1'b0), .W1(4), .W2(3)) uut_single (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr[1]), .s_awvalid(awvalid[1]), .s_awready(awready[1]),
    .s_wdata(wdata[1]), .s_wstrb(wstrb[1]), .s_wvalid(wvalid[1]), .s_wready(wready[1]),
    .s_bresp(bresp[1]), .s_bvalid(bvalid[1]), .s_bready(bready[1]),
    .s_araddr(araddr[1]), .s_arvalid(arvalid[1]), .s_arready(arready[1]),
    .s_rdata(rdata[1]), .s_rresp(rresp[1]), .s_rvalid(rvalid[1]), .s_rready(rready[1]),
    .ch1_in(s1_in), .ch1_out(s1_out), .ch1_hiz(s1_hiz), .ch1_in_sync(s1_sync),
    .ch2_in(s2_in), .ch2_out(s2_out), .ch2_hiz(s2_hiz), .ch2_in_sync(s2_sync)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(int k, logic [8:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    awaddr[k] = a; wdata[k] = d; wstrb[k] = s;
    awvalid[k] = 1'b1; wvalid[k] = 1'b1; bready[k] = 1'b1;
    #1;
    while (!awready[k]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    awvalid[k] = 1'b0; wvalid[k] = 1'b0;
    while (!bvalid[k]) begin @(negedge clk); end
    check("R11 bresp", 32'(bresp[k]), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic bus_read(int k, logic [8:0] a, output logic [31:0] v);
    @(negedge clk);
    araddr[k] = a; arvalid[k] = 1'b1; rready[k] = 1'b1;
    #1;
    while (!arready[k]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    arvalid[k] = 1'b0;
    while (!rvalid[k]) begin @(negedge clk); end
    check("R11 rresp", 32'(rresp[k]), 32'h0);
    v = rdata[k];
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    check("R1 ch1_out", 32'(c1_out), 32'hA5);
    check("R1 ch1_hiz", 32'(c1_hiz), 32'h0F);
    check("R1 ch2_out", 32'(c2_out), 32'h0);
    check("R1 ch2_hiz", 32'(c2_hiz), 32'hFFF);
    check("R1 single ch1_hiz default", 32'(s1_hiz), 32'hF);
    check("R1 single ch1_out default", 32'(s1_out), 32'h0);
    bus_read(0, 9'h4, v);
    check("R7 dir1 readback", v, 32'h0F);
    bus_read(0, 9'hC, v);
    check("R10 dir2 upper bits zero", v, 32'hFFF);
  endtask

  task automatic t_strobe_output;
    logic [31:0] v;
    bus_write(0, 9'h4, 32'h0, 4'h0);
    @(negedge clk);
    check("R3 R7 dir1 write with zero strobes", 32'(c1_hiz), 32'h00);
    bus_read(0, 9'h4, v);
    check("R7 dir1 readback", v, 32'h0);
    bus_write(0, 9'h0, 32'hFFFF_FF3C, 4'h0);
    @(negedge clk);
    check("R4 R3 ch1_out", 32'(c1_out), 32'h3C);
    bus_read(0, 9'h0, v);
    check("R6 R10 output bits read zero", v, 32'h0);
  endtask

  task automatic t_input_mask;
    logic [31:0] v;
    bus_write(0, 9'h4, 32'hF0, 4'hF);
    @(negedge clk);
    c1_in = 8'hA6;
    repeat (3) @(posedge clk);
    bus_read(0, 9'h0, v);
    check("R6 mixed read", v, 32'hA0);
    bus_write(0, 9'h0, 32'hC5, 4'hF);
    @(negedge clk);
    check("R5 input bits keep value", 32'(c1_out), 32'h35);
    bus_write(0, 9'h4, 32'h0, 4'hF);
    @(negedge clk);
    check("R5 kept value on turning output", 32'(c1_out), 32'h35);
  endtask

  task automatic t_sync;
    @(negedge clk);
    c1_in = 8'h5B;
    @(negedge clk);
    check("R6 sync after one edge", 32'(c1_sync), 32'hA6);
    @(negedge clk);
    check("R6 sync after two edges", 32'(c1_sync), 32'h5B);
  endtask

  task automatic t_chan2;
    logic [31:0] v;
    bus_write(0, 9'hC, 32'h0F0, 4'hF);
    @(negedge clk);
    check("R8 ch2_hiz", 32'(c2_hiz), 32'h0F0);
    bus_write(0, 9'h8, 32'hABC, 4'hF);
    @(negedge clk);
    check("R8 ch2_out masked", 32'(c2_out), 32'hA0C);
    check("R8 ch1_out untouched", 32'(c1_out), 32'h35);
    c2_in = 12'h155;
    repeat (3) @(posedge clk);
    bus_read(0, 9'h8, v);
    check("R8 R6 ch2 data read", v, 32'h050);
    bus_read(0, 9'hC, v);
    check("R8 dir2 readback", v, 32'h0F0);
  endtask

  task automatic t_needs_both;
    @(negedge clk);
    awaddr[0] = 9'h0; wdata[0] = 32'hFF; awvalid[0] = 1'b1; wvalid[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 awready with address only", 32'(awready[0]), 32'h0);
    check("R2 no response with address only", 32'(bvalid[0]), 32'h0);
    awvalid[0] = 1'b0; wvalid[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 wready with data only", 32'(wready[0]), 32'h0);
    check("R2 ch1_out unchanged", 32'(c1_out), 32'h35);
    wvalid[0] = 1'b0;
  endtask

  task automatic t_outside;
    logic [31:0] v;
    bus_write(0, 9'h10, 32'hFF, 4'hF);
    @(negedge clk);
    check("R10 write outside map ch1_out", 32'(c1_out), 32'h35);
    check("R10 write outside map ch1_hiz", 32'(c1_hiz), 32'h00);
    check("R10 write outside map ch2_out", 32'(c2_out), 32'hA0C);
    bus_read(0, 9'h10, v);
    check("R10 read outside map", v, 32'h0);
    bus_read(0, 9'h1C, v);
    check("R10 read outside map high", v, 32'h0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    araddr[0] = 9'hC; arvalid[0] = 1'b1; rready[0] = 1'b0;
    #1;
    while (!arready[0]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    araddr[0] = 9'h0;
    awaddr[0] = 9'h0; wdata[0] = 32'h00; awvalid[0] = 1'b1; wvalid[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 rvalid held", 32'(rvalid[0]), 32'h1);
    check("R11 rdata held", rdata[0], 32'h0F0);
    check("R2 no address accepted while pending", 32'({arready[0], awready[0]}), 32'h0);
    check("R2 pending write not applied", 32'(c1_out), 32'h35);
    awvalid[0] = 1'b0; wvalid[0] = 1'b0; arvalid[0] = 1'b0; rready[0] = 1'b1;
    @(posedge clk); #1;
    check("R11 rvalid drops after accept", 32'(rvalid[0]), 32'h0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    bus_write(1, 9'h8, 32'h7, 4'hF);
    bus_write(1, 9'hC, 32'h0, 4'hF);
    @(negedge clk);
    check("R9 ch2_out stays zero", 32'(s2_out), 32'h0);
    check("R9 ch2_hiz stays ones", 32'(s2_hiz), 32'h7);
    bus_read(1, 9'h8, v);
    check("R9 ch2 data reads zero", v, 32'h0);
    bus_read(1, 9'hC, v);
    check("R9 ch2 dir reads zero", v, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      awaddr[k] = '0; awvalid[k] = 1'b0; wdata[k] = '0; wstrb[k] = '0; wvalid[k] = 1'b0;
      bready[k] = 1'b1; araddr[k] = '0; arvalid[k] = 1'b0; rready[k] = 1'b1;
    end
    c1_in = '0; c2_in = '0; s1_in = '0; s2_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_strobe_output();
    t_input_mask();
    t_sync();
    t_chan2();
    t_needs_both();
    t_outside();
    t_hold();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule